// File: doc/BRIEF.md
# Mean Shift Position Iteration Controller

This block refines the position of a tracking window inside one video frame by repeated weighted-centroid steps. A start pulse seeds the iteration with the object position found in the previous frame. For every step the block opens a pass. Upstream logic streams the pixels of the candidate window centred on the current position, each pixel carrying its coordinates and a weight. The block sums the weights and the weight-scaled coordinates. It then divides to get the new centre and decides whether to stop or to run another pass.

The kernel-derivative term is constant inside the window, so only the pixel weights enter the sums. There are four ways to stop. The step can become small: the L1 distance between the new and the old centre is below a programmable threshold. The centre can oscillate: the new centre equals the centre from two steps earlier. The programmed iteration cap can be reached. Or the weight sum of a pass can be zero, in which case the current centre is kept and no division takes place. When the block stops, it pulses `done` and holds the final centre, the stop reason and the iteration count until the next start.

Top module: `ms_iter_ctrl`

## Requirements
- R1: After reset `done`, `busy` and `pass_ready` are low and `ctr_x`, `ctr_y` and `iter_cnt` are zero.
- R2: A `start` accepted while idle loads `ctr_x`/`ctr_y` from `start_x`/`start_y`, clears `iter_cnt` and opens the first pass (`pass_ready` high); the centre shown during each pass is the centre that pass is measured from.
- R3: At the end of a pass with a non-zero weight sum, the new centre on each axis is floor(sum(coord*w)/sum(w)) over the pixels accepted with `pix_valid` while `pass_ready` was high; the pass ends with the pixel that has `pix_last` set.
- R4: If |new_x-old_x|+|new_y-old_y| < `eps`, the block stops with `stop_why` = 0 and the new centre on `ctr_x`/`ctr_y`.
- R5: From the second pass on, if the new centre equals the centre from two passes earlier and R4 does not apply, the block stops with `stop_why` = 1 and the new centre.
- R6: The iteration cap is `max_iter`, with 0 read as 1 and values above 20 read as 20. When pass number `iter_cnt` reaches the cap and neither R4 nor R5 applies, the block stops with `stop_why` = 2 and the new centre.
- R7: A pass whose weight sum is zero stops the block with `stop_why` = 3, `ctr_x`/`ctr_y` unchanged, and that pass counted in `iter_cnt`.
- R8: Stop reasons have the priority zero weight (3) > small step (0) > oscillation (1) > cap (2).
- R9: Pixels presented while `pass_ready` is low, and `start` while `busy` is high, have no effect.
- R10: `done` is high for exactly one cycle per run, and `ctr_x`, `ctr_y`, `stop_why` and `iter_cnt` hold their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run from the seed position |
| start_x | input | 11 | Seed column (previous-frame position) |
| start_y | input | 11 | Seed row (previous-frame position) |
| eps | input | 12 | L1 step threshold, sampled at start |
| max_iter | input | 5 | Iteration cap, sampled at start |
| pix_valid | input | 1 | Pixel on the pixel inputs is valid |
| pix_last | input | 1 | Final pixel of the current pass |
| pix_x | input | 11 | Pixel column |
| pix_y | input | 11 | Pixel row |
| pix_w | input | 16 | Pixel weight, unsigned fixed point |
| pass_ready | output | 1 | A pass is open and pixels are accepted |
| busy | output | 1 | A run is in progress |
| ctr_x | output | 11 | Current or final centre column |
| ctr_y | output | 11 | Current or final centre row |
| done | output | 1 | One-cycle pulse when a run ends |
| stop_why | output | 2 | 0 small step, 1 oscillation, 2 cap, 3 zero weight |
| iter_cnt | output | 5 | Passes completed in this run |

## Verification
The stop test can meet more than one condition at a time. The bench sets this up on purpose so that the priority decides the reported reason. In one run the cap is 2 and the second pass repeats the pixels of the first, so the step falls under the threshold on exactly the pass that hits the cap; a stop reason of 0 with `iter_cnt` = 2 is expected. In another run the cap is 1 and the only pass carries zero weights, so the zero-weight hold and the cap coincide; reason 3 with the seed position kept is expected. A scoreboard model of the iteration predicts the centre at each pass and the final result of each run, and compares them with the ports.

// File: rtl/ms_pkg.sv
package ms_pkg;

    localparam int CRD_W  = 11;
    localparam int WGT_W  = 16;
    localparam int ITER_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACCUM  = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_DIV    = 3'd3,
        ST_CHECK  = 3'd4
    } ms_state_e;

    // Stop reason codes seen on the stop_why port
    typedef enum logic [1:0] {
        WHY_CONV = 2'd0,
        WHY_OSC  = 2'd1,
        WHY_CAP  = 2'd2,
        WHY_ZERO = 2'd3
    } ms_why_e;

endpackage

// File: rtl/ms_accum.sv
module ms_accum #(
    parameter int CRD_W   = 11,
    parameter int WGT_W   = 16,
    parameter int MAX_PIX = 4096,
    localparam int CNT_W  = $clog2(MAX_PIX + 1),
    localparam int SX_W   = CRD_W + WGT_W + CNT_W,
    localparam int SW_W   = WGT_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    input  logic [WGT_W-1:0] w,
    output logic [SX_W-1:0]  sum_xw,
    output logic [SX_W-1:0]  sum_yw,
    output logic [SW_W-1:0]  sum_w
);

    typedef struct packed {
        logic [SX_W-1:0] sx;
        logic [SX_W-1:0] sy;
        logic [SW_W-1:0] sw;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d.sx = acc_q.sx + SX_W'(x * w);
            acc_d.sy = acc_q.sy + SX_W'(y * w);
            acc_d.sw = acc_q.sw + SW_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum_xw = acc_q.sx;
    assign sum_yw = acc_q.sy;
    assign sum_w  = acc_q.sw;

    // R3: a cleared accumulator starts the pass from zero
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q.sw == '0 && acc_q.sx == '0 && acc_q.sy == '0));

endmodule

// File: rtl/ms_divider.sv
module ms_divider #(
    parameter int NUM_W  = 40,
    parameter int DEN_W  = 29,
    parameter int Q_W    = 11,
    localparam int IDX_W = (Q_W > 1) ? $clog2(Q_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quot,
    output logic             fin
);

    typedef struct packed {
        logic             busy;
        logic             fin;
        logic [IDX_W-1:0] idx;
        logic [NUM_W-1:0] num;
        logic [NUM_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [Q_W-1:0]   q;
    } div_t;

    div_t dv_d, dv_q;
    logic [NUM_W:0] trial;

    always_comb begin
        dv_d     = dv_q;
        dv_d.fin = 1'b0;
        trial    = {{(NUM_W + 1 - DEN_W){1'b0}}, dv_q.den} << dv_q.idx;
        if (go) begin
            dv_d.busy = 1'b1;
            dv_d.idx  = IDX_W'(Q_W - 1);
            dv_d.num  = num;
            dv_d.rem  = num;
            dv_d.den  = den;
            dv_d.q    = '0;
        end else if (dv_q.busy) begin
            if ({1'b0, dv_q.rem} >= trial) begin
                dv_d.rem          = dv_q.rem - trial[NUM_W-1:0];
                dv_d.q[dv_q.idx]  = 1'b1;
            end
            if (dv_q.idx == '0) begin
                dv_d.busy = 1'b0;
                dv_d.fin  = 1'b1;
            end else begin
                dv_d.idx = dv_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign quot = dv_q.q;
    assign fin  = dv_q.fin;

    // R3: the finished quotient is the floor of num/den
    assert_div_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.fin |-> ((NUM_W + 1)'(dv_q.q) * (NUM_W + 1)'(dv_q.den)
                      + (NUM_W + 1)'(dv_q.rem) == (NUM_W + 1)'(dv_q.num)
                      && dv_q.rem < NUM_W'(dv_q.den)));

endmodule

// File: rtl/ms_stop_check.sv
module ms_stop_check
    import ms_pkg::*;
#(
    parameter int CRD_W  = 11,
    parameter int ITER_W = 5
) (
    input  logic [CRD_W-1:0]  nx,
    input  logic [CRD_W-1:0]  ny,
    input  logic [CRD_W-1:0]  cx,
    input  logic [CRD_W-1:0]  cy,
    input  logic [CRD_W-1:0]  ox,
    input  logic [CRD_W-1:0]  oy,
    input  logic              have_old,
    input  logic [CRD_W:0]    eps,
    input  logic [ITER_W-1:0] iter,
    input  logic [ITER_W-1:0] lim,
    output logic              stop,
    output ms_why_e           why
);

    logic [CRD_W-1:0] dx, dy;
    logic [CRD_W:0]   step;
    logic             small_step, osc, cap;

    always_comb begin
        dx         = (nx >= cx) ? (nx - cx) : (cx - nx);
        dy         = (ny >= cy) ? (ny - cy) : (cy - ny);
        step       = {1'b0, dx} + {1'b0, dy};
        small_step = step < eps;
        osc        = have_old && (nx == ox) && (ny == oy);
        cap        = iter >= lim;
        stop       = small_step || osc || cap;
        if (small_step)  why = WHY_CONV;
        else if (osc)    why = WHY_OSC;
        else             why = WHY_CAP;
    end

endmodule

// File: rtl/ms_iter_ctrl.sv
module ms_iter_ctrl
    import ms_pkg::*;
#(
    parameter int CRD_W    = ms_pkg::CRD_W,
    parameter int WGT_W    = ms_pkg::WGT_W,
    parameter int ITER_W   = ms_pkg::ITER_W,
    parameter int ITER_MAX = 20,
    parameter int MAX_PIX  = 4096,
    localparam int CNT_W   = $clog2(MAX_PIX + 1),
    localparam int SX_W    = CRD_W + WGT_W + CNT_W,
    localparam int SW_W    = WGT_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CRD_W-1:0]  start_x,
    input  logic [CRD_W-1:0]  start_y,
    input  logic [CRD_W:0]    eps,
    input  logic [ITER_W-1:0] max_iter,
    input  logic              pix_valid,
    input  logic              pix_last,
    input  logic [CRD_W-1:0]  pix_x,
    input  logic [CRD_W-1:0]  pix_y,
    input  logic [WGT_W-1:0]  pix_w,
    output logic              pass_ready,
    output logic              busy,
    output logic [CRD_W-1:0]  ctr_x,
    output logic [CRD_W-1:0]  ctr_y,
    output logic              done,
    output logic [1:0]        stop_why,
    output logic [ITER_W-1:0] iter_cnt
);

    typedef struct packed {
        ms_state_e         st;
        logic [CRD_W-1:0]  cx;
        logic [CRD_W-1:0]  cy;
        logic [CRD_W-1:0]  ox;
        logic [CRD_W-1:0]  oy;
        logic [ITER_W-1:0] iter;
        logic [ITER_W-1:0] lim;
        logic [CRD_W:0]    eps;
        logic              done;
        ms_why_e           why;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              acc_clr, acc_en, div_go;
    logic [SX_W-1:0]   acc_num [2];
    logic [SW_W-1:0]   acc_sw;
    logic [CRD_W-1:0]  div_q   [2];
    logic [1:0]        div_fin;
    logic              chk_stop;
    ms_why_e           chk_why;
    logic [ITER_W-1:0] lim_in;

    ms_accum #(
        .CRD_W  (CRD_W),
        .WGT_W  (WGT_W),
        .MAX_PIX(MAX_PIX)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .x     (pix_x),
        .y     (pix_y),
        .w     (pix_w),
        .sum_xw(acc_num[0]),
        .sum_yw(acc_num[1]),
        .sum_w (acc_sw)
    );

    // one divider per axis, both launched together
    for (genvar g = 0; g < 2; g++) begin : g_axis
        ms_divider #(
            .NUM_W(SX_W),
            .DEN_W(SW_W),
            .Q_W  (CRD_W)
        ) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (div_go),
            .num  (acc_num[g]),
            .den  (acc_sw),
            .quot (div_q[g]),
            .fin  (div_fin[g])
        );
    end

    ms_stop_check #(
        .CRD_W (CRD_W),
        .ITER_W(ITER_W)
    ) u_stop (
        .nx      (div_q[0]),
        .ny      (div_q[1]),
        .cx      (ctl_q.cx),
        .cy      (ctl_q.cy),
        .ox      (ctl_q.ox),
        .oy      (ctl_q.oy),
        .have_old(ctl_q.iter >= ITER_W'(2)),
        .eps     (ctl_q.eps),
        .iter    (ctl_q.iter),
        .lim     (ctl_q.lim),
        .stop    (chk_stop),
        .why     (chk_why)
    );

    always_comb begin
        if (max_iter == '0)                     lim_in = ITER_W'(1);
        else if (max_iter > ITER_W'(ITER_MAX))  lim_in = ITER_W'(ITER_MAX);
        else                                    lim_in = max_iter;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        acc_clr    = 1'b0;
        acc_en     = 1'b0;
        div_go     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.cx   = start_x;
                    ctl_d.cy   = start_y;
                    ctl_d.iter = '0;
                    ctl_d.lim  = lim_in;
                    ctl_d.eps  = eps;
                    ctl_d.st   = ST_ACCUM;
                    acc_clr    = 1'b1;
                end
            end
            ST_ACCUM: begin
                acc_en = pix_valid;
                if (pix_valid && pix_last) ctl_d.st = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                ctl_d.iter = ctl_q.iter + 1'b1;
                if (acc_sw == '0) begin
                    ctl_d.done = 1'b1;
                    ctl_d.why  = WHY_ZERO;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    div_go   = 1'b1;
                    ctl_d.st = ST_DIV;
                end
            end
            ST_DIV: begin
                if (&div_fin) ctl_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                ctl_d.ox = ctl_q.cx;
                ctl_d.oy = ctl_q.cy;
                ctl_d.cx = div_q[0];
                ctl_d.cy = div_q[1];
                if (chk_stop) begin
                    ctl_d.done = 1'b1;
                    ctl_d.why  = chk_why;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    acc_clr  = 1'b1;
                    ctl_d.st = ST_ACCUM;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.why <= WHY_CONV;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pass_ready = (ctl_q.st == ST_ACCUM);
    assign busy       = (ctl_q.st != ST_IDLE);
    assign ctr_x      = ctl_q.cx;
    assign ctr_y      = ctl_q.cy;
    assign done       = ctl_q.done;
    assign stop_why   = ctl_q.why;
    assign iter_cnt   = ctl_q.iter;

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an accepted start seeds the centre and opens a pass
    assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && start) |=>
            (ctr_x == $past(start_x) && ctr_y == $past(start_y)
             && iter_cnt == '0 && pass_ready));

    // R7: zero weight sum ends the run and keeps the centre
    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LAUNCH && acc_sw == '0) |=>
            (done && stop_why == 2'd3 && $stable(ctr_x) && $stable(ctr_y)));

    // R6: no run reports more passes than its cap
    assert_iter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iter_cnt >= ITER_W'(1) && iter_cnt <= ctl_q.lim
                  && ctl_q.lim <= ITER_W'(ITER_MAX)));

    // R8: the cap reason only appears on the capped pass
    assert_cap_reason_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stop_why == 2'd2) |-> (iter_cnt == ctl_q.lim));

    // R9: while idle without start, nothing moves
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !start) |=>
            ($stable(ctr_x) && $stable(ctr_y) && !pass_ready && !busy));

endmodule

// File: tb/ms_iter_ctrl_tb_top.sv
module ms_iter_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [10:0] start_x, start_y;
    logic [11:0] eps;
    logic [4:0]  max_iter;
    logic        pix_valid, pix_last;
    logic [10:0] pix_x, pix_y;
    logic [15:0] pix_w;
    logic        pass_ready, busy, done;
    logic [10:0] ctr_x, ctr_y;
    logic [1:0]  stop_why;
    logic [4:0]  iter_cnt;

    always #10 clk = ~clk;

    ms_iter_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_x(start_x),
        .start_y(start_y), .eps(eps), .max_iter(max_iter),
        .pix_valid(pix_valid), .pix_last(pix_last), .pix_x(pix_x),
        .pix_y(pix_y), .pix_w(pix_w), .pass_ready(pass_ready),
        .busy(busy), .ctr_x(ctr_x), .ctr_y(ctr_y), .done(done),
        .stop_why(stop_why), .iter_cnt(iter_cnt)
    );

    typedef struct {
        string tag;
        int    x;
        int    y;
        int    why;
        int    it;
    } exp_t;

    exp_t sb[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_done = 0;
    bit   finished = 0;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops an expected result on every completion pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && done === 1'b1) begin
                n_done++;
                if (sb.size() == 0) begin
                    check("R10", "unexpected done", 1, 0);
                end else begin
                    mon_e = sb.pop_front();
                    check(mon_e.tag, "final x", ctr_x, mon_e.x);
                    check(mon_e.tag, "final y", ctr_y, mon_e.y);
                    check(mon_e.tag, "stop reason", stop_why, mon_e.why);
                    check(mon_e.tag, "iterations", iter_cnt, mon_e.it);
                end
            end
        end
    end

    function automatic int off_x(int seed, int j);
        return ((seed * 7 + j * 13) % 7) - 3;
    endfunction
    function automatic int off_y(int seed, int j);
        return ((seed * 5 + j * 11) % 7) - 3;
    endfunction
    function automatic int wgt(int seed, int j);
        return (seed * 97 + j * 131 + 17) % 4001;
    endfunction

    // pass plan: target centre and pixel seed for pass k
    task automatic plan(input int mode, input int k, input int sx, input int sy,
                        output int tx, output int ty, output int seed, output bit zero);
        zero = 0; tx = sx; ty = sy; seed = 1;
        case (mode)
            0: begin tx = sx + 30; ty = sy - 20; seed = 1; end
            1: begin
                tx = sx + 40;
                if (k % 2 == 1) begin ty = sy; seed = 2; end
                else begin ty = sy + 25; seed = 3; end
            end
            2: begin tx = sx + 8 * k; ty = sy + 8 * k; seed = k + 10; end
            3: begin
                if (k == 1) begin tx = sx + 10; seed = 4; end
                else zero = 1;
            end
            default: zero = 1;
        endcase
    endtask

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic run_case(string tag, int sx, int sy, int e, int mi, int mode, bit noise);
        int  cx = sx, cy = sy, ox = 0, oy = 0, k = 0, lim, tx, ty, seed;
        bit  zero, stop = 0;
        int  want_done;
        exp_t ex;
        lim = (mi == 0) ? 1 : ((mi > 20) ? 20 : mi);
        want_done = n_done + 1;
        @(negedge clk);
        start = 1; start_x = 11'(sx); start_y = 11'(sy);
        eps = 12'(e); max_iter = 5'(mi);
        @(negedge clk);
        start = 0;
        while (!stop) begin
            longint swx = 0, swy = 0, sw = 0;
            int nx, ny, step;
            while (pass_ready !== 1'b1) @(negedge clk);
            k++;
            check(tag, "R2 pass centre x", ctr_x, cx);
            check(tag, "R2 pass centre y", ctr_y, cy);
            plan(mode, k, sx, sy, tx, ty, seed, zero);
            for (int j = 0; j < 8; j++) begin
                int px = tx + off_x(seed, j);
                int py = ty + off_y(seed, j);
                int pw = zero ? 0 : wgt(seed, j);
                pix_valid = 1; pix_last = (j == 7);
                pix_x = 11'(px); pix_y = 11'(py); pix_w = 16'(pw);
                swx += longint'(px) * pw; swy += longint'(py) * pw; sw += pw;
                @(negedge clk);
            end
            pix_valid = 0; pix_last = 0;
            if (noise) begin
                // stray pixels and a stray start while the pass is closed
                for (int j = 0; j < 3; j++) begin
                    pix_valid = 1; pix_last = (j == 2);
                    pix_x = 11'd2000; pix_y = 11'd3; pix_w = 16'hFFFF;
                    start = (k == 1 && j == 1); start_x = 11'd5; start_y = 11'd6;
                    @(negedge clk);
                end
                pix_valid = 0; pix_last = 0; start = 0;
            end
            ex.tag = tag; ex.it = k;
            if (sw == 0) begin
                stop = 1; ex.why = 3; ex.x = cx; ex.y = cy;
            end else begin
                nx = int'(swx / sw); ny = int'(swy / sw);
                step = iabs(nx - cx) + iabs(ny - cy);
                ex.x = nx; ex.y = ny;
                if (step < e) begin stop = 1; ex.why = 0; end
                else if (k >= 2 && nx == ox && ny == oy) begin stop = 1; ex.why = 1; end
                else if (k >= lim) begin stop = 1; ex.why = 2; end
                else begin ox = cx; oy = cy; cx = nx; cy = ny; end
            end
            if (stop) sb.push_back(ex);
        end
        while (n_done < want_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 0; start = 0; start_x = 0; start_y = 0; eps = 0; max_iter = 0;
        pix_valid = 0; pix_last = 0; pix_x = 0; pix_y = 0; pix_w = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "done", done, 0);
        check("R1", "busy", busy, 0);
        check("R1", "pass_ready", pass_ready, 0);
        check("R1", "ctr_x", ctr_x, 0);
        check("R1", "ctr_y", ctr_y, 0);
        check("R1", "iter_cnt", iter_cnt, 0);
        // R9 pixels while idle have no effect
        pix_valid = 1; pix_last = 1; pix_x = 11'd77; pix_y = 11'd88; pix_w = 16'd999;
        repeat (2) @(negedge clk);
        pix_valid = 0; pix_last = 0;
        check("R9", "idle pixel ctr_x", ctr_x, 0);
        check("R9", "idle pixel pass_ready", pass_ready, 0);

        run_case("R4 small step",         500, 400, 3, 10, 0, 0);
        run_case("R5 oscillation",        300, 300, 3, 10, 1, 0);
        run_case("R6 cap of four",        500, 500, 2,  4, 2, 0);
        run_case("R7 zero weight hold",   200, 600, 3, 10, 3, 0);
        run_case("R8 step beats cap",     700, 100, 3,  2, 0, 0);
        run_case("R8 zero beats cap",      50,  50, 3,  1, 5, 0);
        run_case("R6 cap zero reads one", 400, 400, 2,  0, 2, 0);
        run_case("R6 cap clamps to 20",   100, 100, 2, 31, 2, 0);
        run_case("R9 stray input",        900, 900, 3, 10, 2, 1);
        run_case("R3 centroid floor",     1000, 700, 3, 10, 0, 1);

        // R10 result held after completion
        repeat (5) @(negedge clk);
        check("R10", "done stays low", done, 0);
        check("R10", "busy low", busy, 0);
        check("R10", "held x", ctr_x, mon_e.x);
        check("R10", "held y", ctr_y, mon_e.y);
        check("R10", "held reason", stop_why, mon_e.why);
        check("R10", "held iterations", iter_cnt, mon_e.it);
        check("R10", "scoreboard drained", sb.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule